// File: doc/BRIEF.md
# Packed Signed Halving Add/Subtract Unit

This unit is a small SIMD arithmetic stage for a 32-bit datapath. It takes two 32-bit operands and a 2-bit operation code. It views each operand either as two signed 16-bit halves or as four signed 8-bit bytes. It adds or subtracts the operands lane by lane and halves each lane result with an arithmetic shift right by one bit. The halved lane results are packed back into one 32-bit word.

Two of the modes cross the halves. One half of operand A is paired with the opposite half of operand B. One of the resulting pairs is added and the other is subtracted.

Each lane result is formed one bit wider than the lane before it is halved. Because of this the result always fits the lane, and the unit needs neither overflow handling nor saturation. It drives no condition flags.

An operation is accepted on any cycle where `in_valid` is high. Its result appears on the registered output one clock later, together with `out_valid`.

Top module: `phadd_unit`

## Requirements
- R1: With `op` = 2'b00, each 16-bit half of `result` is floor((A_half + B_half) / 2). A_half and B_half are the same half ([31:16] or [15:0]) of each operand, taken as signed values.
- R2: With `op` = 2'b01, each byte of `result` is floor((A_byte + B_byte) / 2). A_byte and B_byte are the same byte position of each operand, taken as signed 8-bit values.
- R3: With `op` = 2'b10, `result[31:16]` = floor((A[31:16] + B[15:0]) / 2) and `result[15:0]` = floor((A[15:0] − B[31:16]) / 2), all signed.
- R4: With `op` = 2'b11, `result[31:16]` = floor((A[31:16] − B[15:0]) / 2) and `result[15:0]` = floor((A[15:0] + B[31:16]) / 2), all signed.
- R5: Results never overflow. Adding the most-negative value to itself returns the most-negative value: 0x8000 for halves, 0x80 for bytes. Adding the most-positive value to itself returns the most-positive value: 0x7FFF for halves.
- R6: Halving rounds toward negative infinity. A lane sum of −1 gives −1, and a lane sum of +1 gives 0.
- R7: No carry or borrow crosses a lane boundary. In byte mode, 0x00FF00FF + 0x00010001 gives 0x00000000. The same operands in halfword mode give 0x00800080.
- R8: `out_valid` is high exactly one clock after a cycle with `in_valid` high, and low one clock after a cycle with `in_valid` low. The result for an accepted operation appears in that same cycle.
- R9: While `in_valid` is low, `result` holds its last value.
- R10: A synchronous active-high `rst` clears `out_valid` and `result` to zero at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and op are valid this cycle |
| op | input | 2 | Operation code: 00 halfword add, 01 byte add, 10 add/sub with exchange, 11 sub/add with exchange |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B |
| out_valid | output | 1 | Result is valid |
| result | output | 32 | Packed halved lane results |

## Verification
Every accepted operation is due exactly one clock edge after it is driven. The driver applies operands on a falling edge and queues the expected word. The monitor checks `out_valid` on the next falling edge, pops the queue there and compares the value. Two cases are checked directly at the ports on the falling edge after the relevant rising edge: a result that is held through idle cycles, and the reset clearing of the output.

// File: rtl/phadd_pkg.sv
package phadd_pkg;

    typedef enum logic [1:0] {
        OP_HADD = 2'b00,
        OP_BADD = 2'b01,
        OP_ASX  = 2'b10,
        OP_SAX  = 2'b11
    } phadd_op_e;

endpackage

// File: rtl/phadd_lane.sv
// One signed lane: full-precision add or subtract, then halve.
module phadd_lane #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y
);
    logic [W:0] ext_a;
    logic [W:0] ext_b;
    logic [W:0] wide;

    always_comb begin
        ext_a = {a[W-1], a};
        ext_b = {b[W-1], b};
        wide  = sub ? (ext_a - ext_b) : (ext_a + ext_b);
        // bits [W:1] of the widened value are the floor-halved result
        y     = W'(wide >> 1);
    end
endmodule

// File: rtl/phadd_route.sv
// Picks halfword operand pairs and add/sub per half for the current op.
module phadd_route
    import phadd_pkg::*;
#(
    parameter int HW = 16
) (
    input  logic [1:0]      op,
    input  logic [2*HW-1:0] opa,
    input  logic [2*HW-1:0] opb,
    output logic [HW-1:0]   hi_a,
    output logic [HW-1:0]   hi_b,
    output logic            hi_sub,
    output logic [HW-1:0]   lo_a,
    output logic [HW-1:0]   lo_b,
    output logic            lo_sub
);
    logic xchg;

    always_comb begin
        xchg   = (op == OP_ASX) || (op == OP_SAX);
        hi_a   = opa[2*HW-1:HW];
        lo_a   = opa[HW-1:0];
        hi_b   = xchg ? opb[HW-1:0]    : opb[2*HW-1:HW];
        lo_b   = xchg ? opb[2*HW-1:HW] : opb[HW-1:0];
        hi_sub = (op == OP_SAX);
        lo_sub = (op == OP_ASX);
    end
endmodule

// File: rtl/phadd_unit.sv
module phadd_unit
    import phadd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        op,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    localparam int HW     = DATA_W / 2;
    localparam int BW     = HW / 2;
    localparam int NBYTES = DATA_W / BW;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] res;
    } state_t;

    state_t state_d, state_q;

    logic [HW-1:0]     hi_a, hi_b, lo_a, lo_b, hi_y, lo_y;
    logic              hi_sub, lo_sub;
    logic [DATA_W-1:0] byte_res;
    logic [DATA_W-1:0] calc;

    phadd_route #(.HW(HW)) u_route (
        .op     (op),
        .opa    (opa),
        .opb    (opb),
        .hi_a   (hi_a),
        .hi_b   (hi_b),
        .hi_sub (hi_sub),
        .lo_a   (lo_a),
        .lo_b   (lo_b),
        .lo_sub (lo_sub)
    );

    phadd_lane #(.W(HW)) u_hi (.a(hi_a), .b(hi_b), .sub(hi_sub), .y(hi_y));
    phadd_lane #(.W(HW)) u_lo (.a(lo_a), .b(lo_b), .sub(lo_sub), .y(lo_y));

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        phadd_lane #(.W(BW)) u_b (
            .a   (opa[i*BW +: BW]),
            .b   (opb[i*BW +: BW]),
            .sub (1'b0),
            .y   (byte_res[i*BW +: BW])
        );
    end

    always_comb begin
        calc          = (op == OP_BADD) ? byte_res : {hi_y, lo_y};
        state_d       = state_q;
        state_d.valid = in_valid;
        if (in_valid) begin
            state_d.res = calc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.valid;
    assign result    = state_q.res;
endmodule

// File: rtl/phadd_unit_chk.sv
module phadd_unit_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [1:0]        op,
    input logic [DATA_W-1:0] opa,
    input logic [DATA_W-1:0] opb,
    input logic              out_valid,
    input logic [DATA_W-1:0] result
);
    localparam int HW = DATA_W / 2;

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0));

    // R8
    valid_pass_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R8
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    // R1
    hadd_self_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'b00 && opa == opb) |=> (result == $past(opa)));

    // R2
    badd_self_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'b01 && opa == opb) |=> (result == $past(opa)));

    // R3
    asx_swap_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'b10 && opa == {opb[HW-1:0], opb[DATA_W-1:HW]})
        |=> (result == {$past(opa[DATA_W-1:HW]), {HW{1'b0}}}));

    // R4
    sax_swap_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'b11 && opa == {opb[HW-1:0], opb[DATA_W-1:HW]})
        |=> (result == {{HW{1'b0}}, $past(opa[HW-1:0])}));
endmodule

bind phadd_unit phadd_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op        (op),
    .opa       (opa),
    .opb       (opb),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/sim_phadd_unit.sv
`timescale 1ns/1ps
module sim_phadd_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        out_valid;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];

    always #5 clk = ~clk;

    phadd_unit u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op        (op),
        .opa       (opa),
        .opb       (opb),
        .out_valid (out_valid),
        .result    (result)
    );

    // floor(x/2) written without shifts
    function automatic int floor_half(int x);
        if (x >= 0) return x / 2;
        return -((1 - x) / 2);
    endfunction

    function automatic logic [31:0] ref_calc(logic [1:0] o, logic [31:0] a, logic [31:0] b);
        logic [31:0] r;
        int s;
        r = '0;
        case (o)
            2'b00: for (int i = 0; i < 2; i++) begin
                s = floor_half(int'($signed(a[16*i +: 16])) + int'($signed(b[16*i +: 16])));
                r[16*i +: 16] = s[15:0];
            end
            2'b01: for (int i = 0; i < 4; i++) begin
                s = floor_half(int'($signed(a[8*i +: 8])) + int'($signed(b[8*i +: 8])));
                r[8*i +: 8] = s[7:0];
            end
            2'b10: begin
                s = floor_half(int'($signed(a[31:16])) + int'($signed(b[15:0])));
                r[31:16] = s[15:0];
                s = floor_half(int'($signed(a[15:0])) - int'($signed(b[31:16])));
                r[15:0] = s[15:0];
            end
            default: begin
                s = floor_half(int'($signed(a[31:16])) - int'($signed(b[15:0])));
                r[31:16] = s[15:0];
                s = floor_half(int'($signed(a[15:0])) + int'($signed(b[31:16])));
                r[15:0] = s[15:0];
            end
        endcase
        return r;
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(logic [1:0] o, logic [31:0] a, logic [31:0] b, logic [31:0] exp, string tag);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1;
        op  = o;
        opa = a;
        opb = b;
        it.exp = exp;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor: result due on the falling edge after the capturing rising edge
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R8 unexpected out_valid", result, 32'h0);
                end else begin
                    it = sb.pop_front();
                    check(result === it.exp, it.tag, result, it.exp);
                end
            end
        end
    end

    initial begin
        logic [31:0] held;
        logic [31:0] a, b;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0 && result === 32'h0, "R10 reset state", result, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        drive(2'b00, 32'h0003_FFF0, 32'h0005_0002, 32'h0004_FFF9, "R1 halfword add");
        drive(2'b01, 32'h1020_F004, 32'h0204_F0FC, 32'h0912_F000, "R2 byte add");
        drive(2'b10, 32'h0004_0006, 32'h0002_0008, 32'h0006_0002, "R3 add/sub exchange");
        drive(2'b11, 32'h0004_0006, 32'h0002_0008, 32'hFFFE_0004, "R4 sub/add exchange");
        drive(2'b00, 32'h8000_8000, 32'h8000_8000, 32'h8000_8000, "R5 most-negative halves");
        drive(2'b00, 32'h7FFF_7FFF, 32'h7FFF_7FFF, 32'h7FFF_7FFF, "R5 most-positive halves");
        drive(2'b01, 32'h8080_8080, 32'h8080_8080, 32'h8080_8080, "R5 most-negative bytes");
        drive(2'b10, 32'h8000_8000, 32'h7FFF_8000, 32'h8000_8000, "R5 exchange extremes");
        drive(2'b00, 32'hFFFF_0001, 32'h0000_0000, 32'hFFFF_0000, "R6 rounding toward -inf");
        drive(2'b01, 32'hFF01_FD03, 32'h0000_0000, 32'hFF00_FE01, "R6 byte rounding");
        drive(2'b01, 32'h00FF_00FF, 32'h0001_0001, 32'h0000_0000, "R7 no carry across bytes");
        drive(2'b00, 32'h00FF_00FF, 32'h0001_0001, 32'h0080_0080, "R7 halfword carry kept");
        drive(2'b11, 32'h0000_0000, 32'h0000_0001, 32'hFFFF_0000, "R7 no borrow across halves");
        idle(2);

        held = result;
        idle(3);
        check(result === held && out_valid === 1'b0, "R9 hold while idle", result, held);

        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 100; k++) begin
                a = $urandom;
                b = $urandom;
                drive(2'(m), a, b, ref_calc(2'(m), a, b),
                      (m == 0) ? "R1 random" : (m == 1) ? "R2 random" :
                      (m == 2) ? "R3 random" : "R4 random");
            end
        end
        idle(2);
        check(out_valid === 1'b0, "R8 valid drops", {31'h0, out_valid}, 32'h0);

        drive(2'b00, 32'h1234_5678, 32'h1234_5678, 32'h1234_5678, "R8 single op");
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0 && result === 32'h0, "R10 reset clears", result, 32'h0);
        rst = 1'b0;
        idle(2);
        check(sb.size() == 0, "R8 all results seen", 32'(sb.size()), 32'h0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            repeat (200000) @(posedge clk);
        join_any
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule